// File: doc/BRIEF.md
# Pair Issue Sequencer

This block takes a 64-bit instruction packet, splits it into two 32-bit sub-instructions and decides how they go to the two execution units: a memory-side unit and an integer-side unit. Two format bits in the packet select one of four modes. Both halves can issue together in one cycle. They can issue one after the other, with the upper half first or with the lower half first. A long packet issues as a single 64-bit operation.

Each issue port carries a valid flag, a unit-select code and the instruction bits. In the same cycle, the unit returns a branch flag and target, a kill-next flag and a system-register-move flag. The block pulses a commit strobe to the write-back logic after every issue step. It then ends the packet with a one-cycle done pulse. That pulse carries the packet's branch target, or no target, and an error flag for two branches in the same cycle.

Packets are accepted only while the block is idle. One packet is in flight at a time.

Top module: `pair_issue_seq`

## Requirements
- R1: While reset is held and after its release, `pkt_ready` is 1. All issue, commit, done, result and flag outputs are 0.
- R2: The packet mode is formed as {pkt_data[0], pkt_data[32]}, with bit 0 as the high bit of the mode. 0 = paired, 1 = upper-first, 2 = lower-first, 3 = long. The upper half `pkt_data[63:32]` is the left sub-instruction and the lower half is the right one.
- R3: In a paired packet, the cycle after acceptance issues the left half on port A with unit code 0 (memory) and the right half on port B with unit code 1 (integer). Both issue in that cycle with a single commit, and done follows in the next cycle.
- R4: For a paired packet, if exactly one port branched, done reports that port's target with `br_valid` = 1. If both branched, `br_conflict` = 1, `br_valid` = 0 and the target is 0. The kill-next response does not suppress port B in a paired packet.
- R5: In an upper-first packet, the left half issues alone on port A with unit 0 and a commit. The next cycle issues the right half on port B with unit code 2 (any unit) and a commit. Done follows one cycle later.
- R6: In a lower-first packet, the right half issues first on port A with unit 1. The left half then issues on port B with unit 2.
- R7: In a sequential packet, if the first issue reports a branch or kill-next, the second half is not issued and done follows in the next cycle. The branch target of the first issue is reported.
- R8: In a sequential packet where the second half issues and branches, done reports the second half's target.
- R9: A long packet issues once on port A with unit code 3. `a_insn` carries the upper half and `b_insn` the lower half, `b_issue` stays 0, and there is one commit. Done follows in the next cycle with port A's branch result.
- R10: `flag_kill` records a kill-next response on port A. `flag_sysmv` records a system-register-move response on either issuing port. Each flag shows from the cycle after the response through the done cycle. Both flags are cleared when a packet is accepted and when the block leaves done.
- R11: Responses on a port that is not issuing in that cycle have no effect. `pkt_valid` and `pkt_data` have no effect while `pkt_ready` is 0.
- R12: `done` lasts one cycle. `br_valid`, `br_target` and `br_conflict` are 0 whenever `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_data | input | 64 | Packet, left half in the upper bits |
| pkt_ready | output | 1 | Block is idle and takes a packet |
| a_issue | output | 1 | Port A (first or left) issues this cycle |
| a_unit | output | 2 | Port A unit code: 0 memory, 1 integer, 2 any, 3 long |
| a_insn | output | 32 | Port A instruction bits |
| b_issue | output | 1 | Port B (second or right) issues this cycle |
| b_unit | output | 2 | Port B unit code |
| b_insn | output | 32 | Port B instruction bits; lower half of a long packet |
| a_br | input | 1 | Port A branched |
| a_tgt | input | 32 | Port A branch target |
| a_kill | input | 1 | Port A asks to suppress the next half |
| a_sysmv | input | 1 | Port A moved a system register |
| b_br | input | 1 | Port B branched |
| b_tgt | input | 32 | Port B branch target |
| b_sysmv | input | 1 | Port B moved a system register |
| commit | output | 1 | Write-back commit strobe |
| done | output | 1 | Packet finished |
| br_valid | output | 1 | A branch target is reported |
| br_target | output | 32 | Reported branch target |
| br_conflict | output | 1 | Both paired halves branched |
| flag_kill | output | 1 | Kill-next seen in this packet |
| flag_sysmv | output | 1 | System-register move seen in this packet |

## Verification
An accepted packet's first issue and commit appear one cycle after the accepting edge. The second sequential issue appears one cycle after that. Done appears one cycle after the last issue. A response flag shows in the cycle after the response that set it.

The bench builds the expected output of every cycle of a packet into a queue before driving the packet. It drives inputs and compares the full output set at each falling edge, so every latency is checked exactly rather than within a window. Responses are held constant across the whole packet, so any use of a response while its port is not issuing shows up as a mismatch.

// File: rtl/pis_pkg.sv
// Package: shared types of the pair issue sequencer.
// Assumes two-bit mode and unit codes as listed in the brief.
package pis_pkg;
    typedef enum logic [1:0] {
        KIND_PAIR  = 2'd0,
        KIND_UPPER = 2'd1,
        KIND_LOWER = 2'd2,
        KIND_LONG  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        UNIT_MEM  = 2'd0,
        UNIT_INT  = 2'd1,
        UNIT_ANY  = 2'd2,
        UNIT_WIDE = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_DONE   = 2'd3
    } state_e;
endpackage

// File: rtl/pis_decode.sv
// Module: pis_decode
// Splits a packet into its left and right halves and extracts the mode.
// Assumes the mode high bit sits at bit 0 and the low bit at bit INSN_W.
module pis_decode
    import pis_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [2*INSN_W-1:0] pkt,
    output kind_e               kind,
    output logic [INSN_W-1:0]   left_insn,
    output logic [INSN_W-1:0]   right_insn
);
    // Purpose: half split and mode extraction.
    always_comb begin
        left_insn  = pkt[2*INSN_W-1:INSN_W];
        right_insn = pkt[INSN_W-1:0];
        kind       = kind_e'({pkt[0], pkt[INSN_W]});
    end
endmodule

// File: rtl/pis_route.sv
// Module: pis_route
// Maps the packet mode to what goes on the first and second issue steps.
// Assumes a long packet uses only the first step, with the lower half carried along.
module pis_route
    import pis_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  kind_e             kind,
    input  logic [INSN_W-1:0] left_insn,
    input  logic [INSN_W-1:0] right_insn,
    output logic [INSN_W-1:0] first_insn,
    output unit_e             first_unit,
    output logic [INSN_W-1:0] second_insn,
    output unit_e             second_unit,
    output logic              paired,
    output logic              has_second
);
    // Purpose: per-mode routing of halves to steps and units.
    always_comb begin
        first_insn  = left_insn;
        first_unit  = UNIT_MEM;
        second_insn = right_insn;
        second_unit = UNIT_ANY;
        paired      = 1'b0;
        has_second  = 1'b1;
        unique case (kind)
            KIND_PAIR: begin
                second_unit = UNIT_INT;
                paired      = 1'b1;
            end
            KIND_UPPER: begin
                first_unit  = UNIT_MEM;
            end
            KIND_LOWER: begin
                first_insn  = right_insn;
                first_unit  = UNIT_INT;
                second_insn = left_insn;
            end
            KIND_LONG: begin
                first_unit  = UNIT_WIDE;
                has_second  = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pis_ctrl.sv
// Module: pis_ctrl
// Four-state sequencer: idle, first step, second step, done.
// Assumes unit responses arrive in the same cycle as the issue they answer.
module pis_ctrl
    import pis_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pkt_valid,
    input  logic   paired,
    input  logic   has_second,
    input  logic   first_br,
    input  logic   first_kill,
    output state_e state,
    output logic   accept
);
    state_e state_nx;

    // Purpose: a packet is taken only from idle.
    always_comb accept = (state == ST_IDLE) && pkt_valid;

    // Purpose: next-state choice, including suppression of the second step.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_FIRST;
            ST_FIRST: begin
                if (!has_second || paired)     state_nx = ST_DONE;
                else if (first_br || first_kill) state_nx = ST_DONE;
                else                           state_nx = ST_SECOND;
            end
            ST_SECOND: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Purpose: state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/pis_result.sv
// Module: pis_result
// Collects branch outcome and the per-packet kill and system-move flags.
// Assumes a_fire/b_fire are high only in the cycle the port issues.
module pis_result
    import pis_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  state_e            state,
    input  logic              a_fire,
    input  logic              b_fire,
    input  logic              a_br,
    input  logic [ADDR_W-1:0] a_tgt,
    input  logic              a_kill,
    input  logic              a_sysmv,
    input  logic              b_br,
    input  logic [ADDR_W-1:0] b_tgt,
    input  logic              b_sysmv,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_tgt,
    output logic              res_conflict,
    output logic              flag_kill,
    output logic              flag_sysmv
);
    // Purpose: branch merge; cleared on each new packet.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            res_valid    <= 1'b0;
            res_tgt      <= '0;
            res_conflict <= 1'b0;
        end else if (a_fire && b_fire) begin
            res_valid    <= a_br ^ b_br;
            res_conflict <= a_br & b_br;
            if (a_br && !b_br)      res_tgt <= a_tgt;
            else if (b_br && !a_br) res_tgt <= b_tgt;
            else                    res_tgt <= '0;
        end else if (a_fire && a_br) begin
            res_valid <= 1'b1;
            res_tgt   <= a_tgt;
        end else if (b_fire && b_br) begin
            res_valid <= 1'b1;
            res_tgt   <= b_tgt;
        end
    end

    // Purpose: sticky flags, cleared at packet start and on leaving done.
    always_ff @(posedge clk) begin
        if (!rst_n || accept || state == ST_DONE) begin
            flag_kill  <= 1'b0;
            flag_sysmv <= 1'b0;
        end else begin
            if (a_fire && a_kill) flag_kill <= 1'b1;
            if ((a_fire && a_sysmv) || (b_fire && b_sysmv)) flag_sysmv <= 1'b1;
        end
    end
endmodule

// File: rtl/pair_issue_seq.sv
// Module: pair_issue_seq (top)
// Accepts one packet at a time, issues its halves per mode, commits after
// each step and pulses done with the branch outcome.
// Assumes execution units answer combinationally in the issue cycle.
module pair_issue_seq
    import pis_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int ADDR_W = 32,
    localparam int PKT_W = 2 * INSN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [PKT_W-1:0]  pkt_data,
    output logic              pkt_ready,
    output logic              a_issue,
    output logic [1:0]        a_unit,
    output logic [INSN_W-1:0] a_insn,
    output logic              b_issue,
    output logic [1:0]        b_unit,
    output logic [INSN_W-1:0] b_insn,
    input  logic              a_br,
    input  logic [ADDR_W-1:0] a_tgt,
    input  logic              a_kill,
    input  logic              a_sysmv,
    input  logic              b_br,
    input  logic [ADDR_W-1:0] b_tgt,
    input  logic              b_sysmv,
    output logic              commit,
    output logic              done,
    output logic              br_valid,
    output logic [ADDR_W-1:0] br_target,
    output logic              br_conflict,
    output logic              flag_kill,
    output logic              flag_sysmv
);
    logic [PKT_W-1:0]  pkt_q;
    kind_e             kind;
    logic [INSN_W-1:0] left_insn, right_insn, first_insn, second_insn;
    unit_e             first_unit, second_unit;
    logic              paired, has_second, accept;
    state_e            state;
    logic              res_valid, res_conflict;
    logic [ADDR_W-1:0] res_tgt;

    // Purpose: hold the accepted packet for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)      pkt_q <= '0;
        else if (accept) pkt_q <= pkt_data;
    end

    pis_decode #(.INSN_W(INSN_W)) u_decode (
        .pkt        (pkt_q),
        .kind       (kind),
        .left_insn  (left_insn),
        .right_insn (right_insn)
    );

    pis_route #(.INSN_W(INSN_W)) u_route (
        .kind        (kind),
        .left_insn   (left_insn),
        .right_insn  (right_insn),
        .first_insn  (first_insn),
        .first_unit  (first_unit),
        .second_insn (second_insn),
        .second_unit (second_unit),
        .paired      (paired),
        .has_second  (has_second)
    );

    pis_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_valid  (pkt_valid),
        .paired     (paired),
        .has_second (has_second),
        .first_br   (a_br),
        .first_kill (a_kill),
        .state      (state),
        .accept     (accept)
    );

    // Purpose: issue ports and commit strobe decoded from the state.
    always_comb begin
        pkt_ready = (state == ST_IDLE);
        a_issue   = (state == ST_FIRST);
        b_issue   = (state == ST_SECOND) || (a_issue && paired);
        a_unit    = a_issue ? first_unit : 2'd0;
        a_insn    = a_issue ? first_insn : '0;
        b_unit    = b_issue ? second_unit : 2'd0;
        b_insn    = (b_issue || (a_issue && !has_second)) ? second_insn : '0;
        commit    = a_issue || b_issue;
        done      = (state == ST_DONE);
    end

    pis_result #(.ADDR_W(ADDR_W)) u_result (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .state        (state),
        .a_fire       (a_issue),
        .b_fire       (b_issue),
        .a_br         (a_br),
        .a_tgt        (a_tgt),
        .a_kill       (a_kill),
        .a_sysmv      (a_sysmv),
        .b_br         (b_br),
        .b_tgt        (b_tgt),
        .b_sysmv      (b_sysmv),
        .res_valid    (res_valid),
        .res_tgt      (res_tgt),
        .res_conflict (res_conflict),
        .flag_kill    (flag_kill),
        .flag_sysmv   (flag_sysmv)
    );

    // Purpose: results shown only during the done pulse.
    always_comb begin
        br_valid    = done && res_valid;
        br_target   = done ? res_tgt : '0;
        br_conflict = done && res_conflict;
    end
endmodule

// File: rtl/pis_checker.sv
// Module: pis_checker
// Protocol properties of pair_issue_seq, attached with bind.
// Assumes unit codes 0 memory, 1 integer, 2 any, 3 long.
module pis_checker #(
    parameter int INSN_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_ready,
    input logic              a_issue,
    input logic [1:0]        a_unit,
    input logic              b_issue,
    input logic [1:0]        b_unit,
    input logic              a_br,
    input logic              a_kill,
    input logic              commit,
    input logic              done,
    input logic              br_valid,
    input logic [ADDR_W-1:0] br_target,
    input logic              br_conflict,
    input logic              flag_kill,
    input logic              flag_sysmv
);
    assert_pair_units_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_issue && b_issue) |-> (a_unit == 2'd0 && b_unit == 2'd1));

    assert_done_after_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(commit));

    assert_conflict_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        br_conflict |-> !br_valid);

    assert_late_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_issue && !a_issue) |-> (b_unit == 2'd2));

    assert_suppress_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_issue && !b_issue && a_unit != 2'd3 && (a_br || a_kill)) |=> (!b_issue && done));

    assert_wide_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_issue && a_unit == 2'd3) |-> !b_issue);

    assert_flags_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (!flag_kill && !flag_sysmv));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_quiet_results_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!br_valid && !br_conflict && br_target == '0));
endmodule

bind pair_issue_seq pis_checker #(.INSN_W(INSN_W), .ADDR_W(ADDR_W)) u_pis_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_ready   (pkt_ready),
    .a_issue     (a_issue),
    .a_unit      (a_unit),
    .b_issue     (b_issue),
    .b_unit      (b_unit),
    .a_br        (a_br),
    .a_kill      (a_kill),
    .commit      (commit),
    .done        (done),
    .br_valid    (br_valid),
    .br_target   (br_target),
    .br_conflict (br_conflict),
    .flag_kill   (flag_kill),
    .flag_sysmv  (flag_sysmv)
);

// File: tb/pair_issue_seq_bench.sv
`timescale 1ns/1ps
module pair_issue_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [63:0] pkt_data = '0;
    logic        pkt_ready, a_issue, b_issue, commit, done, br_valid, br_conflict;
    logic        flag_kill, flag_sysmv;
    logic [1:0]  a_unit, b_unit;
    logic [31:0] a_insn, b_insn, br_target;
    logic        a_br = 0, a_kill = 0, a_sysmv = 0, b_br = 0, b_sysmv = 0;
    logic [31:0] a_tgt = '0, b_tgt = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct packed {
        logic        rdy;
        logic        ai;
        logic [1:0]  au;
        logic [31:0] ax;
        logic        bi;
        logic [1:0]  bu;
        logic [31:0] bx;
        logic        cm;
        logic        dn;
        logic        bv;
        logic [31:0] bt;
        logic        bc;
        logic        fk;
        logic        fs;
    } obs_t;

    obs_t exp_q[$];

    always #10 clk = ~clk;

    pair_issue_seq u_pair_issue_seq (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_ready(pkt_ready), .a_issue(a_issue), .a_unit(a_unit), .a_insn(a_insn),
        .b_issue(b_issue), .b_unit(b_unit), .b_insn(b_insn),
        .a_br(a_br), .a_tgt(a_tgt), .a_kill(a_kill), .a_sysmv(a_sysmv),
        .b_br(b_br), .b_tgt(b_tgt), .b_sysmv(b_sysmv),
        .commit(commit), .done(done), .br_valid(br_valid), .br_target(br_target),
        .br_conflict(br_conflict), .flag_kill(flag_kill), .flag_sysmv(flag_sysmv)
    );

    function automatic obs_t observe();
        return '{pkt_ready, a_issue, a_unit, a_insn, b_issue, b_unit, b_insn,
                 commit, done, br_valid, br_target, br_conflict, flag_kill, flag_sysmv};
    endfunction

    function automatic obs_t idle_obs();
        obs_t o = '0;
        o.rdy = 1'b1;
        return o;
    endfunction

    task automatic compare(input obs_t e, input string tag);
        obs_t a = observe();
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    // Builds the expected cycles of one packet, drives it and checks each cycle.
    task automatic run_pkt(input logic [1:0] ty, input logic [31:0] l, input logic [31:0] r,
                           input logic abr, input logic [31:0] atg, input logic akl, input logic asm,
                           input logic bbr, input logic [31:0] btg, input logic bsm,
                           input bit noisy, input string tag);
        logic [31:0] L, R, fi, si;
        logic [1:0]  fu, su;
        bit paired, wide, skip;
        obs_t e;
        L = {l[31:1], ty[0]};
        R = {r[31:1], ty[1]};
        paired = (ty == 2'd0);
        wide   = (ty == 2'd3);
        fi = (ty == 2'd2) ? R : L;
        si = (ty == 2'd2) ? L : R;
        fu = (ty == 2'd0 || ty == 2'd1) ? 2'd0 : (ty == 2'd2 ? 2'd1 : 2'd3);
        su = paired ? 2'd1 : 2'd2;
        skip = paired || wide || abr || akl;
        // first issue cycle
        e = '0; e.ai = 1; e.au = fu; e.ax = fi; e.cm = 1;
        e.bi = paired; e.bu = paired ? su : 2'd0; e.bx = (paired || wide) ? si : '0;
        exp_q.push_back(e);
        if (!skip) begin
            e = '0; e.bi = 1; e.bu = su; e.bx = si; e.cm = 1; e.fk = akl; e.fs = asm;
            exp_q.push_back(e);
            e = '0; e.dn = 1; e.bv = bbr; e.bt = bbr ? btg : '0; e.fs = asm | bsm;
            exp_q.push_back(e);
        end else if (paired) begin
            e = '0; e.dn = 1; e.bv = abr ^ bbr; e.bc = abr & bbr;
            e.bt = (abr && !bbr) ? atg : ((bbr && !abr) ? btg : '0);
            e.fk = akl; e.fs = asm | bsm;
            exp_q.push_back(e);
        end else begin
            e = '0; e.dn = 1; e.bv = abr; e.bt = abr ? atg : '0; e.fk = akl; e.fs = asm;
            exp_q.push_back(e);
        end
        compare(idle_obs(), {tag, " idle before packet"});
        pkt_valid = 1'b1; pkt_data = {L, R};
        a_br = abr; a_tgt = atg; a_kill = akl; a_sysmv = asm;
        b_br = bbr; b_tgt = btg; b_sysmv = bsm;
        while (exp_q.size() > 0) begin
            @(negedge clk);
            if (noisy) begin pkt_valid = 1'b1; pkt_data = ~{L, R}; end
            else pkt_valid = 1'b0;
            compare(exp_q.pop_front(), tag);
        end
        pkt_valid = 1'b0;
        a_br = 0; a_kill = 0; a_sysmv = 0; b_br = 0; b_sysmv = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare(idle_obs(), "R1 reset held");
        rst_n = 1'b1;
        @(negedge clk);
        compare(idle_obs(), "R1 after release");
        // R2 R3: paired, no branch
        run_pkt(2'd0, 32'hA1B2C3D4, 32'h11223344, 0, 32'h0, 0, 0, 0, 32'h0, 0, 0, "R2 R3 paired");
        // R4: single branch on each side, both, kill ignored in paired
        run_pkt(2'd0, 32'h01010100, 32'h20202020, 1, 32'h00001000, 0, 0, 0, 32'h00002000, 0, 0, "R4 paired left branch");
        run_pkt(2'd0, 32'h01010100, 32'h20202020, 0, 32'h00001000, 1, 0, 1, 32'h00002000, 0, 0, "R4 R10 paired right branch with kill");
        run_pkt(2'd0, 32'h5555AAAA, 32'hAAAA5555, 1, 32'h00003000, 0, 0, 1, 32'h00004000, 0, 0, "R4 paired conflict");
        // R5 R10: upper first, system moves on both
        run_pkt(2'd1, 32'hDEADBEEF, 32'h0BADF00D, 0, 32'h0, 0, 1, 0, 32'h0, 1, 0, "R5 R10 upper first");
        // R6 R8: lower first, second branches
        run_pkt(2'd2, 32'hCAFE0000, 32'h0000FACE, 0, 32'h0, 0, 0, 1, 32'h00008888, 0, 0, "R6 R8 lower first");
        // R7: first branch suppresses second; R11 b response ignored
        run_pkt(2'd1, 32'h12345678, 32'h9ABCDEF0, 1, 32'h00007770, 0, 0, 1, 32'h00009990, 1, 0, "R7 R11 upper first branch");
        run_pkt(2'd2, 32'h12345678, 32'h9ABCDEF0, 0, 32'h00007770, 1, 1, 1, 32'h00009990, 0, 0, "R7 R10 lower first kill");
        // R9: long, without and with branch
        run_pkt(2'd3, 32'hFEDCBA98, 32'h76543210, 0, 32'h0, 0, 0, 1, 32'h00005550, 0, 0, "R9 R11 long");
        run_pkt(2'd3, 32'h0F0F0F0F, 32'hF0F0F0F0, 1, 32'h0000ABC0, 0, 0, 0, 32'h0, 0, 0, "R9 long branch");
        // R11: input noise while busy
        run_pkt(2'd1, 32'h33334444, 32'h55556666, 0, 32'h0, 0, 0, 0, 32'h0, 0, 1, "R11 R12 busy input ignored");
        compare(idle_obs(), "R10 R12 final idle");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule